// File: doc/BRIEF.md
# Dual-Bank Word-Addressed Memory Map

This block sits between a signal-processing core and its storage. Each cycle it takes up to three word-addressed requests: one on the X data path, one on the Y data path and one on the program-fetch path. Every address is 16 bits and names a whole 24-bit word. The block sends each request to one of four places: the core's own RAM for that space, a constant table ROM, or one of two external 16K-word banks. It returns the selected read data one cycle later.

The X and Y paths each have their own RAM, ROM and external bank, so one X access and one Y access always finish together. A mode register bit overlays two fixed tables on the data window 0x0100 to 0x01FF. On X these are companding expansion tables, and on Y a full sine period. Program addresses above the internal program RAM fall onto the same two external banks. A program access that collides with a data access on the same bank loses that cycle and is reported on a stall output, so the fetch can be retried.

Top module: `dual_bank_mmap`

## Requirements
- R1: An address names one whole 24-bit word. Adjacent addresses hold independent words, and all 24 bits are stored and returned.
- R2: X and Y each have a private 256-word RAM at addresses 0x0000 to 0x00FF. A write there changes no other space. Read data for a request in cycle n appears on the port's rdata in cycle n+1.
- R3: An X request and a Y request issued in the same cycle are both carried out, whether they target internal RAM or the external banks.
- R4: Program addresses 0x0000 to 0x01FF use a private 512-word program RAM, and such accesses never raise p_stall.
- R5: A cycle with mode_we high loads the mode register from mode_wdata. Only bit 2 has an effect, and it enables the table ROM. Reset clears the bit, so after reset the window 0x0100 to 0x01FF on X and Y goes to the external banks.
- R6: With the ROM enabled, an X read of 0x0100+k (k in 0..127) returns 256*(((8*m+132)*2^s)-132), and an X read of 0x0180+k returns 256*(16*m+8) for s=0, else 256*((16*m+264)*2^(s-1)). Here s=k/16 and m=k mod 16.
- R7: With the ROM enabled, a Y read of 0x0100+i (i in 0..255) returns v=floor(16*h*8388607/(81920-4*h)), with q=i mod 128 and h=q*(128-q). For i>=128 it returns the 24-bit two's complement of -v.
- R8: A write to 0x0100 to 0x01FF on X or Y while the ROM is enabled is dropped. No external write is issued, and the words there before the write are unchanged once the ROM is disabled again.
- R9: An X or Y address of 0x0100 or above that is not taken by the ROM goes to that space's external bank (ex_* for X, ey_* for Y), at offset address[13:0].
- R10: A program address of 0x0200 or above goes to the X bank when address bit 14 is 0 and to the Y bank when it is 1, at offset address[13:0]. It reaches the same words that the data paths reach.
- R11: If an external program access and an external data access target the same bank in one cycle, only the data access reaches the bank. p_stall is high in that same cycle, and a program write in that cycle is lost.
- R12: A port's rdata is zero in the cycle after a cycle in which that port made no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load the mode register |
| mode_wdata | input | 8 | Mode value; bit 2 enables the table ROM |
| x_en | input | 1 | X request valid |
| x_we | input | 1 | X request is a write |
| x_addr | input | 16 | X word address |
| x_wdata | input | 24 | X write data |
| x_rdata | output | 24 | X read data, one cycle after the request |
| y_en | input | 1 | Y request valid |
| y_we | input | 1 | Y request is a write |
| y_addr | input | 16 | Y word address |
| y_wdata | input | 24 | Y write data |
| y_rdata | output | 24 | Y read data, one cycle after the request |
| p_en | input | 1 | Program request valid |
| p_we | input | 1 | Program request is a write |
| p_addr | input | 16 | Program word address |
| p_wdata | input | 24 | Program write data |
| p_rdata | output | 24 | Program read data, one cycle after the request |
| p_stall | output | 1 | Program request dropped this cycle because of a bank clash |
| ex_en | output | 1 | X external bank enable |
| ex_we | output | 1 | X external bank write |
| ex_addr | output | 14 | X external bank word offset |
| ex_wdata | output | 24 | X external bank write data |
| ex_rdata | input | 24 | X external bank read data, one cycle after ex_en |
| ey_en | output | 1 | Y external bank enable |
| ey_we | output | 1 | Y external bank write |
| ey_addr | output | 14 | Y external bank word offset |
| ey_wdata | output | 24 | Y external bank write data |
| ey_rdata | input | 24 | Y external bank read data, one cycle after ey_en |

## Verification
The assertions check the routing rules on every cycle. p_stall may only rise for an external program request. During a clash the bank carries the data request's offset and direction. A program request that is not stalled reaches the bank named by address bit 14. A dropped ROM-window write never reaches a bank. External read data is forwarded one cycle later, and idle ports return zero. The bench's scenarios are needed for what depends on stored contents and on the mode history: the table values, the reset value of the ROM enable, aliasing between program and data space, and the loss of a stalled program write.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  localparam int WORD_W = 24;

  // Where a request is routed; the registered copy selects the read mux.
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_IRAM,
    SRC_ROM,
    SRC_EXTX,
    SRC_EXTY
  } src_e;

  // Companding expansion, mu-style curve, positive codes only.
  function automatic logic [WORD_W-1:0] mu_word(int k);
    int seg, man, mag;
    seg = k >> 4;
    man = k & 15;
    mag = (((man << 3) + 132) << seg) - 132;
    return WORD_W'(mag << 8);
  endfunction

  // Companding expansion, A-style curve, positive codes only.
  function automatic logic [WORD_W-1:0] a_word(int k);
    int seg, man, mag;
    seg = k >> 4;
    man = k & 15;
    if (seg == 0) mag = (man << 4) + 8;
    else          mag = ((man << 4) + 264) << (seg - 1);
    return WORD_W'(mag << 8);
  endfunction

  // Full-period sine by a rational approximation, full scale 2^23-1.
  function automatic logic [WORD_W-1:0] sine_word(int i);
    longint q, h, v;
    q = longint'(i % 128);
    h = q * (128 - q);
    v = (h * 16 * 64'sd8388607) / (81920 - 4 * h);
    if (i >= 128) v = -v;
    return WORD_W'(v);
  endfunction

  // sel 0: X window (two companding halves), sel 1: Y window (sine).
  function automatic logic [WORD_W-1:0] rom_word(int sel, int i);
    if (sel == 1)   return sine_word(i);
    else if (i < 128) return mu_word(i);
    else            return a_word(i - 128);
  endfunction

  function automatic logic [WORD_W-1:0] pick_rd(src_e s,
                                                logic [WORD_W-1:0] ram_q,
                                                logic [WORD_W-1:0] rom_q,
                                                logic [WORD_W-1:0] xb_q,
                                                logic [WORD_W-1:0] yb_q);
    case (s)
      SRC_IRAM: return ram_q;
      SRC_ROM:  return rom_q;
      SRC_EXTX: return xb_q;
      SRC_EXTY: return yb_q;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/mmap_word_ram.sv
module mmap_word_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 24,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mmap_const_rom.sv
module mmap_const_rom import mmap_pkg::*; #(
  parameter int WORDS     = 256,
  parameter int TABLE_SEL = 0,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] tbl [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_fill
    assign tbl[i] = rom_word(TABLE_SEL, i);
  end

  always_ff @(posedge clk) rdata <= tbl[addr];
endmodule

// File: rtl/mmap_space_decode.sv
module mmap_space_decode import mmap_pkg::*; #(
  parameter int   AW         = 16,
  parameter int   IRAM_WORDS = 256,
  parameter int   ROM_BASE   = 256,
  parameter int   ROM_WORDS  = 256,
  parameter src_e EXT_SRC    = SRC_EXTX
) (
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          rom_on,
  output src_e          src,
  output logic          iram_we,
  output logic          ext_req,
  output logic          ext_we
);
  localparam logic [AW-1:0] IRAM_LIM = AW'(IRAM_WORDS);
  localparam logic [AW-1:0] WIN_LO   = AW'(ROM_BASE);
  localparam logic [AW-1:0] WIN_HI   = AW'(ROM_BASE + ROM_WORDS - 1);

  logic in_iram, in_win, rom_hit;

  always_comb begin
    in_iram = addr < IRAM_LIM;
    in_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
    rom_hit = rom_on && in_win;
    if (in_iram)      src = SRC_IRAM;
    else if (rom_hit) src = SRC_ROM;
    else              src = EXT_SRC;
    iram_we = en && we && in_iram;
    ext_req = en && (src == EXT_SRC);
    ext_we  = ext_req && we;
  end
endmodule

// File: rtl/dual_bank_mmap.sv
module dual_bank_mmap import mmap_pkg::*; #(
  parameter int AW         = 16,
  parameter int EXT_AW     = 14,
  parameter int DRAM_WORDS = 256,
  parameter int PRAM_WORDS = 512,
  parameter int ROM_BASE   = 256,
  parameter int ROM_WORDS  = 256,
  parameter int MODE_W     = 8,
  parameter int ROM_EN_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              x_en,
  input  logic              x_we,
  input  logic [AW-1:0]     x_addr,
  input  logic [23:0]       x_wdata,
  output logic [23:0]       x_rdata,
  input  logic              y_en,
  input  logic              y_we,
  input  logic [AW-1:0]     y_addr,
  input  logic [23:0]       y_wdata,
  output logic [23:0]       y_rdata,
  input  logic              p_en,
  input  logic              p_we,
  input  logic [AW-1:0]     p_addr,
  input  logic [23:0]       p_wdata,
  output logic [23:0]       p_rdata,
  output logic              p_stall,
  output logic              ex_en,
  output logic              ex_we,
  output logic [EXT_AW-1:0] ex_addr,
  output logic [23:0]       ex_wdata,
  input  logic [23:0]       ex_rdata,
  output logic              ey_en,
  output logic              ey_we,
  output logic [EXT_AW-1:0] ey_addr,
  output logic [23:0]       ey_wdata,
  input  logic [23:0]       ey_rdata
);
  localparam int DW      = WORD_W;
  localparam int DRAM_AW = $clog2(DRAM_WORDS);
  localparam int PRAM_AW = $clog2(PRAM_WORDS);
  localparam int ROM_AW  = $clog2(ROM_WORDS);
  localparam logic [AW-1:0] PRAM_LIM = AW'(PRAM_WORDS);
  localparam logic [AW-1:0] WIN_LO   = AW'(ROM_BASE);
  localparam logic [AW-1:0] WIN_HI   = AW'(ROM_BASE + ROM_WORDS - 1);

  // ---------------- mode register ----------------
  logic rom_on_q;
  logic mode_unused;
  assign mode_unused = ^mode_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)       rom_on_q <= 1'b0;
    else if (mode_we) rom_on_q <= mode_wdata[ROM_EN_BIT];
  end

  // ---------------- data space decode ----------------
  src_e x_src, y_src;
  logic x_iram_we, x_ext_req, x_ext_we;
  logic y_iram_we, y_ext_req, y_ext_we;

  mmap_space_decode #(
    .AW(AW), .IRAM_WORDS(DRAM_WORDS), .ROM_BASE(ROM_BASE),
    .ROM_WORDS(ROM_WORDS), .EXT_SRC(SRC_EXTX)
  ) u_xdec (
    .en(x_en), .we(x_we), .addr(x_addr), .rom_on(rom_on_q),
    .src(x_src), .iram_we(x_iram_we), .ext_req(x_ext_req), .ext_we(x_ext_we)
  );

  mmap_space_decode #(
    .AW(AW), .IRAM_WORDS(DRAM_WORDS), .ROM_BASE(ROM_BASE),
    .ROM_WORDS(ROM_WORDS), .EXT_SRC(SRC_EXTY)
  ) u_ydec (
    .en(y_en), .we(y_we), .addr(y_addr), .rom_on(rom_on_q),
    .src(y_src), .iram_we(y_iram_we), .ext_req(y_ext_req), .ext_we(y_ext_we)
  );

  // ---------------- program space decode and clash ----------------
  logic p_in_iram, p_ext_req, p_bank_y, p_clash, p_go_x, p_go_y, p_iram_we;
  src_e p_src;

  always_comb begin
    p_in_iram = p_addr < PRAM_LIM;
    p_ext_req = p_en && !p_in_iram;
    p_bank_y  = p_addr[EXT_AW];
    p_clash   = p_ext_req && (p_bank_y ? y_ext_req : x_ext_req);
    p_go_x    = p_ext_req && !p_bank_y && !p_clash;
    p_go_y    = p_ext_req &&  p_bank_y && !p_clash;
    p_iram_we = p_en && p_we && p_in_iram;
    if (!p_en)          p_src = SRC_NONE;
    else if (p_in_iram) p_src = SRC_IRAM;
    else if (p_clash)   p_src = SRC_NONE;
    else if (p_bank_y)  p_src = SRC_EXTY;
    else                p_src = SRC_EXTX;
  end

  assign p_stall = p_clash;

  // ---------------- external bank steering (data wins) ----------------
  always_comb begin
    ex_en    = x_ext_req || p_go_x;
    ex_we    = x_ext_req ? x_ext_we : (p_go_x && p_we);
    ex_addr  = x_ext_req ? x_addr[EXT_AW-1:0] : p_addr[EXT_AW-1:0];
    ex_wdata = x_ext_req ? x_wdata : p_wdata;
    ey_en    = y_ext_req || p_go_y;
    ey_we    = y_ext_req ? y_ext_we : (p_go_y && p_we);
    ey_addr  = y_ext_req ? y_addr[EXT_AW-1:0] : p_addr[EXT_AW-1:0];
    ey_wdata = y_ext_req ? y_wdata : p_wdata;
  end

  // ---------------- internal storage ----------------
  logic [DW-1:0] xram_q, yram_q, pram_q, xrom_q, yrom_q;

  mmap_word_ram #(.WORDS(DRAM_WORDS), .DW(DW)) u_xram (
    .clk(clk), .we(x_iram_we), .addr(x_addr[DRAM_AW-1:0]),
    .wdata(x_wdata), .rdata(xram_q));

  mmap_word_ram #(.WORDS(DRAM_WORDS), .DW(DW)) u_yram (
    .clk(clk), .we(y_iram_we), .addr(y_addr[DRAM_AW-1:0]),
    .wdata(y_wdata), .rdata(yram_q));

  mmap_word_ram #(.WORDS(PRAM_WORDS), .DW(DW)) u_pram (
    .clk(clk), .we(p_iram_we), .addr(p_addr[PRAM_AW-1:0]),
    .wdata(p_wdata), .rdata(pram_q));

  mmap_const_rom #(.WORDS(ROM_WORDS), .TABLE_SEL(0)) u_xrom (
    .clk(clk), .addr(x_addr[ROM_AW-1:0]), .rdata(xrom_q));

  mmap_const_rom #(.WORDS(ROM_WORDS), .TABLE_SEL(1)) u_yrom (
    .clk(clk), .addr(y_addr[ROM_AW-1:0]), .rdata(yrom_q));

  // ---------------- read return ----------------
  src_e x_src_q, y_src_q, p_src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_src_q <= SRC_NONE;
      y_src_q <= SRC_NONE;
      p_src_q <= SRC_NONE;
    end else begin
      x_src_q <= (x_en && !x_we) ? x_src : SRC_NONE;
      y_src_q <= (y_en && !y_we) ? y_src : SRC_NONE;
      p_src_q <= (p_en && !p_we) ? p_src : SRC_NONE;
    end
  end

  assign x_rdata = pick_rd(x_src_q, xram_q, xrom_q, ex_rdata, ey_rdata);
  assign y_rdata = pick_rd(y_src_q, yram_q, yrom_q, ex_rdata, ey_rdata);
  assign p_rdata = pick_rd(p_src_q, pram_q, '0, ex_rdata, ey_rdata);

  // ---------------- assertions ----------------
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r11_stall_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
    p_stall |-> (p_en && p_addr >= PRAM_LIM));

  a_r4_no_stall_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (p_en && p_addr < PRAM_LIM) |-> !p_stall);

  a_r11_data_holds_xbank: assert property (@(posedge clk) disable iff (!rst_n)
    (p_stall && !p_addr[EXT_AW]) |-> (ex_en && ex_we == x_we && ex_addr == x_addr[EXT_AW-1:0]));

  a_r11_data_holds_ybank: assert property (@(posedge clk) disable iff (!rst_n)
    (p_stall && p_addr[EXT_AW]) |-> (ey_en && ey_we == y_we && ey_addr == y_addr[EXT_AW-1:0]));

  a_r10_prog_to_xbank: assert property (@(posedge clk) disable iff (!rst_n)
    (p_en && !p_stall && p_addr >= PRAM_LIM && !p_addr[EXT_AW])
      |-> (ex_en && ex_addr == p_addr[EXT_AW-1:0] && ex_we == p_we));

  a_r10_prog_to_ybank: assert property (@(posedge clk) disable iff (!rst_n)
    (p_en && !p_stall && p_addr >= PRAM_LIM && p_addr[EXT_AW])
      |-> (ey_en && ey_addr == p_addr[EXT_AW-1:0] && ey_we == p_we));

  a_r8_rom_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_on_q && x_en && x_we && x_addr >= WIN_LO && x_addr <= WIN_HI && !p_en) |-> !ex_en);

  a_r9_ext_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(x_en && !x_we && x_src == SRC_EXTX)) |-> (x_rdata == ex_rdata));

  a_r12_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!y_en)) |-> (y_rdata == '0));

endmodule

// File: tb/tb_dual_bank_mmap.sv
module tb_dual_bank_mmap;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] K_XW = 3'd0, K_XR = 3'd1, K_YW = 3'd2,
                         K_YR = 3'd3, K_PW = 3'd4, K_PR = 3'd5;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [23:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{K_XW, 16'h0000, 24'hABCDEF, 4'd1},  // R1
    '{K_XW, 16'h0001, 24'h123456, 4'd1},  // R1
    '{K_YW, 16'h0000, 24'h0F0F0F, 4'd2},  // R2
    '{K_XR, 16'h0000, 24'hABCDEF, 4'd1},  // R1
    '{K_XR, 16'h0001, 24'h123456, 4'd1},  // R1
    '{K_YR, 16'h0000, 24'h0F0F0F, 4'd2},  // R2
    '{K_PW, 16'h01FF, 24'h777777, 4'd4},  // R4
    '{K_PW, 16'h0000, 24'h010101, 4'd4},  // R4
    '{K_PR, 16'h01FF, 24'h777777, 4'd4},  // R4
    '{K_PR, 16'h0000, 24'h010101, 4'd4},  // R4
    '{K_XW, 16'h0150, 24'h111111, 4'd9},  // R9
    '{K_YW, 16'h0150, 24'h222222, 4'd9},  // R9
    '{K_XR, 16'h0150, 24'h111111, 4'd9},  // R9
    '{K_YR, 16'h0150, 24'h222222, 4'd9},  // R9
    '{K_PR, 16'h4150, 24'h222222, 4'd10}, // R10 bit14=1 -> Y bank
    '{K_PR, 16'h8150, 24'h111111, 4'd10}, // R10 bit14=0 -> X bank
    '{K_XW, 16'h3FFF, 24'hFEDCBA, 4'd9},  // R9
    '{K_PR, 16'h3FFF, 24'hFEDCBA, 4'd10}, // R10
    '{K_PW, 16'h4200, 24'h333333, 4'd10}, // R10
    '{K_YR, 16'h0200, 24'h333333, 4'd10}, // R10
    '{K_XR, 16'h0000, 24'hABCDEF, 4'd2}   // R2 program write left X RAM alone
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic x_en = 0, x_we = 0, y_en = 0, y_we = 0, p_en = 0, p_we = 0;
  logic [15:0] x_addr = '0, y_addr = '0, p_addr = '0;
  logic [23:0] x_wdata = '0, y_wdata = '0, p_wdata = '0;
  logic [23:0] x_rdata, y_rdata, p_rdata;
  logic p_stall;
  logic ex_en, ex_we, ey_en, ey_we;
  logic [13:0] ex_addr, ey_addr;
  logic [23:0] ex_wdata, ey_wdata;
  logic [23:0] ex_rdata = '0, ey_rdata = '0;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_mmap dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .x_en(x_en), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata), .x_rdata(x_rdata),
    .y_en(y_en), .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata), .y_rdata(y_rdata),
    .p_en(p_en), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_stall(p_stall),
    .ex_en(ex_en), .ex_we(ex_we), .ex_addr(ex_addr), .ex_wdata(ex_wdata), .ex_rdata(ex_rdata),
    .ey_en(ey_en), .ey_we(ey_we), .ey_addr(ey_addr), .ey_wdata(ey_wdata), .ey_rdata(ey_rdata)
  );

  // External banks: synchronous, read-first, one-cycle read latency.
  logic [23:0] bank_x [int];
  logic [23:0] bank_y [int];

  always @(posedge clk) begin
    if (ex_en) begin
      ex_rdata <= bank_x.exists(int'(ex_addr)) ? bank_x[int'(ex_addr)] : 24'h0;
      if (ex_we) bank_x[int'(ex_addr)] = ex_wdata;
    end
    if (ey_en) begin
      ey_rdata <= bank_y.exists(int'(ey_addr)) ? bank_y[int'(ey_addr)] : 24'h0;
      if (ey_we) bank_y[int'(ey_addr)] = ey_wdata;
    end
  end

  // Expected table contents, restated from the requirement formulas.
  function automatic logic [23:0] exp_mu(int k);
    int s = k / 16, m = k % 16;
    return 24'(((8 * m + 132) * (2 ** s) - 132) * 256);
  endfunction

  function automatic logic [23:0] exp_a(int k);
    int s = k / 16, m = k % 16;
    if (s == 0) return 24'((16 * m + 8) * 256);
    return 24'((16 * m + 264) * (2 ** (s - 1)) * 256);
  endfunction

  function automatic logic [23:0] exp_sine(int i);
    longint q = longint'(i % 128);
    longint h = q * (128 - q);
    longint v = (16 * h * 64'sd8388607) / (81920 - 4 * h);
    return (i >= 128) ? 24'(-v) : 24'(v);
  endfunction

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    x_en = 0; x_we = 0; y_en = 0; y_we = 0; p_en = 0; p_we = 0; mode_we = 0;
  endtask

  task automatic set_x(logic we, logic [15:0] a, logic [23:0] d);
    x_en = 1; x_we = we; x_addr = a; x_wdata = d;
  endtask
  task automatic set_y(logic we, logic [15:0] a, logic [23:0] d);
    y_en = 1; y_we = we; y_addr = a; y_wdata = d;
  endtask
  task automatic set_p(logic we, logic [15:0] a, logic [23:0] d);
    p_en = 1; p_we = we; p_addr = a; p_wdata = d;
  endtask

  task automatic set_mode(logic [7:0] v);
    @(negedge clk); mode_we = 1; mode_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic run_op(logic [2:0] kind, logic [15:0] a, logic [23:0] d, string tag);
    @(negedge clk);
    case (kind)
      K_XW: set_x(1'b1, a, d);
      K_XR: set_x(1'b0, a, '0);
      K_YW: set_y(1'b1, a, d);
      K_YR: set_y(1'b0, a, '0);
      K_PW: set_p(1'b1, a, d);
      default: set_p(1'b0, a, '0);
    endcase
    @(negedge clk);
    idle();
    case (kind)
      K_XR: chk(tag, x_rdata, d);
      K_YR: chk(tag, y_rdata, d);
      K_PR: chk(tag, p_rdata, d);
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bank_x[32'h100] = 24'h5A5A5A;
    repeat (3) @(negedge clk);
    // Reset state (R12, R11)
    chk("R12 reset x_rdata", x_rdata, 24'h0);
    chk("R11 reset p_stall", {23'h0, p_stall}, 24'h0);
    chk("R9 reset ex_en", {23'h0, ex_en}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk (R1, R2, R4, R9, R10)
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].kind, VECS[i].addr, VECS[i].data,
             $sformatf("R%0d vec %0d", VECS[i].req, i));
    end

    // R5: ROM disabled out of reset, window goes to X bank
    run_op(K_XR, 16'h0100, 24'h5A5A5A, "R5 rom off after reset");

    // R6 / R7: tables with ROM on
    set_mode(8'h04);
    for (int k = 0; k < 128; k += 25) begin
      run_op(K_XR, 16'(16'h0100 + k), exp_mu(k), $sformatf("R6 mu k=%0d", k));
      run_op(K_XR, 16'(16'h0180 + k), exp_a(k),  $sformatf("R6 a k=%0d", k));
    end
    run_op(K_XR, 16'h017F, exp_mu(127), "R6 mu last");
    run_op(K_XR, 16'h01FF, exp_a(127),  "R6 a last");
    for (int k = 0; k < 256; k += 32) begin
      run_op(K_YR, 16'(16'h0100 + k), exp_sine(k), $sformatf("R7 sine i=%0d", k));
    end
    run_op(K_YR, 16'h0140, 24'h7FFFFF, "R7 sine peak");
    run_op(K_YR, 16'h01C0, 24'h800001, "R7 sine trough");
    run_op(K_YR, 16'h01FF, exp_sine(255), "R7 sine last");

    // R8: window writes dropped while ROM on
    @(negedge clk);
    set_x(1'b1, 16'h0150, 24'hDEAD00);
    set_y(1'b1, 16'h0150, 24'hBEEF00);
    #1;
    chk("R8 no X bank access", {23'h0, ex_en}, 24'h0);
    chk("R8 no Y bank access", {23'h0, ey_en}, 24'h0);
    @(negedge clk); idle();
    run_op(K_XR, 16'h0150, exp_mu(16'h50), "R8 ROM unchanged");

    // R5: other mode bits without bit 2 disable ROM
    set_mode(8'hFB);
    run_op(K_XR, 16'h0150, 24'h111111, "R8 X word kept");
    run_op(K_YR, 16'h0150, 24'h222222, "R8 Y word kept");

    // R3: concurrent X and Y, internal then external
    @(negedge clk); set_x(1'b1, 16'h0010, 24'hAAAAAA); set_y(1'b1, 16'h0010, 24'h555555);
    @(negedge clk); idle(); set_x(1'b0, 16'h0010, '0); set_y(1'b0, 16'h0010, '0);
    @(negedge clk); idle();
    chk("R3 X internal", x_rdata, 24'hAAAAAA);
    chk("R3 Y internal", y_rdata, 24'h555555);
    @(negedge clk); set_x(1'b1, 16'h0400, 24'h010203); set_y(1'b1, 16'h0400, 24'h040506);
    @(negedge clk); idle(); set_x(1'b0, 16'h0400, '0); set_y(1'b0, 16'h0400, '0);
    @(negedge clk); idle();
    chk("R3 X external", x_rdata, 24'h010203);
    chk("R3 Y external", y_rdata, 24'h040506);
    chk("R12 idle P read zero", p_rdata, 24'h0);

    // R11: clash on X bank, data wins, program write lost
    run_op(K_PW, 16'h0300, 24'h444444, "R10 prog write");
    @(negedge clk); set_x(1'b0, 16'h0150, '0); set_p(1'b1, 16'h0300, 24'h999999);
    #1;
    chk("R11 stall on X bank", {23'h0, p_stall}, 24'h000001);
    chk("R11 bank keeps data offset", {10'h0, ex_addr}, 24'h000150);
    @(negedge clk); idle();
    chk("R11 data read served", x_rdata, 24'h111111);
    run_op(K_PR, 16'h0300, 24'h444444, "R11 stalled write lost");

    // R11: clash on Y bank
    @(negedge clk); set_y(1'b0, 16'h0150, '0); set_p(1'b0, 16'h4150, '0);
    #1;
    chk("R11 stall on Y bank", {23'h0, p_stall}, 24'h000001);
    @(negedge clk); idle();
    chk("R11 Y data served", y_rdata, 24'h222222);

    // R10: different banks, no clash
    @(negedge clk); set_x(1'b0, 16'h0150, '0); set_p(1'b0, 16'h4150, '0);
    #1;
    chk("R10 no stall across banks", {23'h0, p_stall}, 24'h0);
    @(negedge clk); idle();
    chk("R10 X data", x_rdata, 24'h111111);
    chk("R10 P from Y bank", p_rdata, 24'h222222);

    // R4: internal program fetch alongside external data never stalls
    @(negedge clk); set_x(1'b0, 16'h0150, '0); set_p(1'b0, 16'h01FF, '0);
    #1;
    chk("R4 internal fetch no stall", {23'h0, p_stall}, 24'h0);
    @(negedge clk); idle();
    chk("R4 internal fetch data", p_rdata, 24'h777777);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule